// File: doc/BRIEF.md
# Register File with Deferred-Exception Poison Tags

This block is a multi-ported register file in which every register carries one poison bit. The bit marks a value that a speculatively executed instruction could not produce because it hit an exception that would end the program. The speculative instruction does not trap. It leaves the poison mark in its destination, and the fault is raised only if the program really consumes that value. A later non-speculative reader of the register raises the fatal exception. A check operation placed where the instruction originally sat tests the register and asks for recovery code to run. Resumable faults, such as a missing page, are reported for immediate service, because servicing them only costs time.

The write port takes the result together with several flags: a speculative flag, an exception flag, the exception class, and a flag saying that one of the producing instruction's sources was already poisoned. Each of the two read ports returns the data and the poison bit in the same cycle. Each read port also takes the consumer's speculative flag, so that the block can tell a harmless speculative use of a poisoned value from a fatal one.

Top module: `poison_regfile`

## Requirements
- R1: After reset every register reads as zero with its poison bit clear, and the fatal, recovery and service outputs are low.
- R2: A writeback with the exception flag low stores its data. The stored value and poison bit appear on either read port in the cycle after the write edge. A read port's data and poison bit follow its index in the same cycle.
- R3: A speculative writeback with the exception flag high and the class input high (1 = program-terminating) sets the destination's poison bit. It raises no output.
- R4: A writeback with the exception flag high and the class low (0 = resumable), speculative or not, pulses `service_o` one cycle later. It leaves the destination's data and poison bit unchanged.
- R5: A read with the port enabled and the consumer's speculative flag low, of a poisoned register, pulses `fatal_o` one cycle later, with `fatal_idx_o` holding the register index. This applies on either port.
- R6: A read with the consumer's speculative flag high returns the poison bit and never raises `fatal_o`.
- R7: A speculative writeback with no exception and the source-poisoned flag high stores its data and sets the destination's poison bit. It raises no output.
- R8: A writeback that neither raises an exception nor sets poison (R3, R7) clears the destination's poison bit.
- R9: A check request pulses `recover_o` one cycle later if and only if the named register is poisoned.
- R10: When both ports make offending reads in the same cycle, a single one-cycle `fatal_o` pulse is produced, with `fatal_idx_o` equal to the lower of the two indices.
- R11: A non-speculative writeback with a terminating-class exception leaves the register's data and poison bit unchanged and raises no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_en | input | 1 | Writeback valid |
| wb_idx | input | IW | Destination register |
| wb_data | input | DW | Result value |
| wb_spec | input | 1 | Producing instruction is speculative |
| wb_exc | input | 1 | Producing instruction faulted |
| wb_fatal | input | 1 | Fault class: 1 terminating, 0 resumable |
| wb_src_poison | input | 1 | A source operand was poisoned |
| rd_en_a | input | 1 | Port A read valid |
| rd_idx_a | input | IW | Port A register |
| rd_spec_a | input | 1 | Port A consumer is speculative |
| rd_data_a | output | DW | Port A data |
| rd_poison_a | output | 1 | Port A poison bit |
| rd_en_b | input | 1 | Port B read valid |
| rd_idx_b | input | IW | Port B register |
| rd_spec_b | input | 1 | Port B consumer is speculative |
| rd_data_b | output | DW | Port B data |
| rd_poison_b | output | 1 | Port B poison bit |
| chk_en | input | 1 | Check request |
| chk_idx | input | IW | Register to check |
| fatal_o | output | 1 | Fatal exception pulse |
| fatal_idx_o | output | IW | Offending register |
| recover_o | output | 1 | Recovery request pulse |
| service_o | output | 1 | Resumable fault to service now |

## Verification
Read data and poison bits are combinational, so they are due in the same cycle as the index. A write becomes visible only after the next rising edge. `fatal_o`, `fatal_idx_o`, `recover_o` and `service_o` are registered and are due exactly one cycle after the edge that captures the request. The bench changes inputs just after a falling edge. It samples read results a moment later in the same half-cycle, and samples registered outputs at the following falling edge. It then returns the inputs to idle and samples again, which confirms that each pulse lasts a single cycle.

// File: rtl/poison_regfile.sv
`timescale 1ns/100ps
module poison_regfile #(
  parameter int NREGS = 16,
  parameter int DW = 32,
  localparam int IW = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wb_en,
  input  logic [IW-1:0] wb_idx,
  input  logic [DW-1:0] wb_data,
  input  logic          wb_spec,
  input  logic          wb_exc,
  input  logic          wb_fatal,
  input  logic          wb_src_poison,
  input  logic          rd_en_a,
  input  logic [IW-1:0] rd_idx_a,
  input  logic          rd_spec_a,
  output logic [DW-1:0] rd_data_a,
  output logic          rd_poison_a,
  input  logic          rd_en_b,
  input  logic [IW-1:0] rd_idx_b,
  input  logic          rd_spec_b,
  output logic [DW-1:0] rd_data_b,
  output logic          rd_poison_b,
  input  logic          chk_en,
  input  logic [IW-1:0] chk_idx,
  output logic          fatal_o,
  output logic [IW-1:0] fatal_idx_o,
  output logic          recover_o,
  output logic          service_o
);

  logic [DW-1:0]    regs_q [NREGS];
  logic [NREGS-1:0] poison_q;

  logic wr_ok, set_psn, off_a, off_b, pick_a;

  assign wr_ok   = wb_en & ~wb_exc;
  assign set_psn = wb_en & wb_spec & ((wb_exc & wb_fatal) | (~wb_exc & wb_src_poison));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
    end else if (wr_ok) begin
      regs_q[wb_idx] <= wb_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       poison_q <= '0;
    else if (set_psn) poison_q[wb_idx] <= 1'b1;
    else if (wr_ok)   poison_q[wb_idx] <= 1'b0;
  end

  assign rd_data_a   = regs_q[rd_idx_a];
  assign rd_poison_a = poison_q[rd_idx_a];
  assign rd_data_b   = regs_q[rd_idx_b];
  assign rd_poison_b = poison_q[rd_idx_b];

  assign off_a  = rd_en_a & ~rd_spec_a & poison_q[rd_idx_a];
  assign off_b  = rd_en_b & ~rd_spec_b & poison_q[rd_idx_b];
  assign pick_a = off_a & (~off_b | (rd_idx_a <= rd_idx_b));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fatal_o     <= 1'b0;
      fatal_idx_o <= '0;
      recover_o   <= 1'b0;
      service_o   <= 1'b0;
    end else begin
      fatal_o     <= off_a | off_b;
      fatal_idx_o <= pick_a ? rd_idx_a : (off_b ? rd_idx_b : '0);
      recover_o   <= chk_en & poison_q[chk_idx];
      service_o   <= wb_en & wb_exc & ~wb_fatal;
    end
  end

  // R8
  clean_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en && !wb_exc && !wb_spec |=> !poison_q[$past(wb_idx)]);

  // R3
  spec_fault_poisons_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en && wb_spec && wb_exc && wb_fatal |=> poison_q[$past(wb_idx)]);

  // R6
  spec_reads_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en_a || rd_spec_a) && (!rd_en_b || rd_spec_b) |=> !fatal_o);

  // R9
  recover_needs_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_en |=> !recover_o);

  // R4
  service_needs_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_en && wb_exc) |=> !service_o);

  // R11
  nonspec_fault_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en && wb_exc && !wb_spec |=> $stable(poison_q));

endmodule

// File: tb/sim_poison_regfile.sv
`timescale 1ns/100ps
module sim_poison_regfile;
  localparam int NREGS = 16;
  localparam int DW = 32;
  localparam int IW = $clog2(NREGS);

  logic clk = 0, rst_n = 0;
  logic wb_en, wb_spec, wb_exc, wb_fatal, wb_src_poison;
  logic [IW-1:0] wb_idx, rd_idx_a, rd_idx_b, chk_idx, fatal_idx_o;
  logic [DW-1:0] wb_data, rd_data_a, rd_data_b;
  logic rd_en_a, rd_spec_a, rd_poison_a, rd_en_b, rd_spec_b, rd_poison_b;
  logic chk_en, fatal_o, recover_o, service_o;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  poison_regfile #(.NREGS(NREGS), .DW(DW)) u0 (.*);

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic idle();
    wb_en = 0; wb_idx = '0; wb_data = '0; wb_spec = 0; wb_exc = 0; wb_fatal = 0; wb_src_poison = 0;
    rd_en_a = 0; rd_idx_a = '0; rd_spec_a = 0; rd_en_b = 0; rd_idx_b = '0; rd_spec_b = 0;
    chk_en = 0; chk_idx = '0;
  endtask

  task automatic wr(input int idx, input logic [DW-1:0] d, input bit spec, input bit exc,
                    input bit fat, input bit srcp);
    @(negedge clk);
    wb_en = 1; wb_idx = IW'(idx); wb_data = d; wb_spec = spec; wb_exc = exc;
    wb_fatal = fat; wb_src_poison = srcp;
    @(negedge clk);
    idle();
  endtask

  task automatic peek(input int idx, output logic [DW-1:0] d, output logic p);
    @(negedge clk);
    rd_en_a = 1; rd_spec_a = 1; rd_idx_a = IW'(idx);
    #1; d = rd_data_a; p = rd_poison_a;
    idle();
  endtask

  task automatic t_reset();
    logic [DW-1:0] d; logic p;
    for (int i = 0; i < NREGS; i++) begin
      peek(i, d, p);
      chk("R1 data", d, 0);
      chk("R1 poison", p, 0);
    end
    chk("R1 outputs", {fatal_o, recover_o, service_o}, 0);
  endtask

  task automatic t_write();
    wr(3, 32'hA5A5_0003, 0, 0, 0, 0);
    wr(4, 32'h0000_1234, 1, 0, 0, 0);
    @(negedge clk);
    rd_en_a = 1; rd_idx_a = 3; rd_en_b = 1; rd_idx_b = 4;
    #1;
    chk("R2 port a data", rd_data_a, 32'hA5A5_0003);
    chk("R2 port b data", rd_data_b, 32'h0000_1234);
    chk("R2 poison clear", {rd_poison_a, rd_poison_b}, 0);
    idle();
  endtask

  task automatic t_spec_fault();
    logic [DW-1:0] d; logic p;
    wr(5, 32'h77, 0, 0, 0, 0);
    @(negedge clk);
    wb_en = 1; wb_idx = 5; wb_data = 32'hDEAD; wb_spec = 1; wb_exc = 1; wb_fatal = 1;
    @(negedge clk);
    idle();
    chk("R3 no outputs", {fatal_o, recover_o, service_o}, 0);
    peek(5, d, p);
    chk("R3 poison set", p, 1);
    @(negedge clk);
    chk("R6 spec read no fatal", fatal_o, 0);
  endtask

  task automatic t_resumable();
    logic [DW-1:0] d; logic p;
    wr(6, 32'h11, 0, 0, 0, 0);
    @(negedge clk);
    wb_en = 1; wb_idx = 6; wb_data = 32'h99; wb_spec = 1; wb_exc = 1; wb_fatal = 0;
    @(negedge clk);
    chk("R4 service spec", service_o, 1);
    wb_spec = 0;
    @(negedge clk);
    chk("R4 service nonspec", service_o, 1);
    idle();
    @(negedge clk);
    chk("R4 service single", service_o, 0);
    peek(6, d, p);
    chk("R4 data kept", d, 32'h11);
    chk("R4 poison kept", p, 0);
  endtask

  task automatic t_fatal_read();
    @(negedge clk);
    rd_en_a = 1; rd_idx_a = 5; rd_spec_a = 0;
    #1; chk("R6 poison visible", rd_poison_a, 1);
    @(negedge clk);
    idle();
    chk("R5 fatal port a", fatal_o, 1);
    chk("R5 index port a", fatal_idx_o, 5);
    @(negedge clk);
    chk("R5 fatal one cycle", fatal_o, 0);
    rd_en_b = 1; rd_idx_b = 5;
    @(negedge clk);
    idle();
    chk("R5 fatal port b", fatal_o, 1);
    chk("R5 index port b", fatal_idx_o, 5);
    @(negedge clk);
    rd_en_a = 1; rd_idx_a = 5; rd_spec_a = 1; rd_en_b = 1; rd_idx_b = 5; rd_spec_b = 1;
    @(negedge clk);
    idle();
    chk("R6 both ports speculative", fatal_o, 0);
  endtask

  task automatic t_propagate();
    logic [DW-1:0] d; logic p;
    wr(7, 32'h42, 1, 0, 0, 1);
    chk("R7 no outputs", {fatal_o, recover_o, service_o}, 0);
    peek(7, d, p);
    chk("R7 data stored", d, 32'h42);
    chk("R7 poison set", p, 1);
  endtask

  task automatic t_check();
    @(negedge clk);
    chk_en = 1; chk_idx = 7;
    @(negedge clk);
    chk("R9 recover on poison", recover_o, 1);
    chk_idx = 3;
    @(negedge clk);
    idle();
    chk("R9 no recover clean", recover_o, 0);
  endtask

  task automatic t_clear();
    logic [DW-1:0] d; logic p;
    wr(7, 32'h8, 0, 0, 0, 0);
    peek(7, d, p);
    chk("R8 nonspec clears", p, 0);
    chk("R8 data", d, 32'h8);
    wr(5, 32'h55, 1, 0, 0, 0);
    peek(5, d, p);
    chk("R8 spec clean clears", p, 0);
    @(negedge clk);
    rd_en_a = 1; rd_idx_a = 5;
    @(negedge clk);
    idle();
    chk("R8 no fatal after clear", fatal_o, 0);
  endtask

  task automatic t_both();
    wr(9, 32'h1, 1, 1, 1, 0);
    wr(2, 32'h1, 1, 1, 1, 0);
    @(negedge clk);
    rd_en_a = 1; rd_idx_a = 9; rd_en_b = 1; rd_idx_b = 2;
    @(negedge clk);
    chk("R10 fatal", fatal_o, 1);
    chk("R10 lowest index b", fatal_idx_o, 2);
    rd_idx_a = 2; rd_idx_b = 9;
    @(negedge clk);
    idle();
    chk("R10 lowest index a", fatal_idx_o, 2);
    @(negedge clk);
    chk("R10 single pulse", fatal_o, 0);
  endtask

  task automatic t_nonspec_term();
    logic [DW-1:0] d; logic p;
    wr(3, 32'hFFFF, 0, 1, 1, 0);
    chk("R11 no outputs", {fatal_o, recover_o, service_o}, 0);
    peek(3, d, p);
    chk("R11 data kept", d, 32'hA5A5_0003);
    chk("R11 poison kept", p, 0);
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_write();
    t_spec_fault();
    t_resumable();
    t_fatal_read();
    t_propagate();
    t_check();
    t_clear();
    t_both();
    t_nonspec_term();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule